// File: doc/BRIEF.md
# Windowed Synchronized Vertical Divider

This block counts half-line clocks (the clock runs at twice the horizontal line rate, so one video line is two counts) and decides when each vertical field ends. A field ends, and the count restarts at 0, either when a separated vertical sync strobe arrives inside the window allowed by the current mode, or when the count reaches that mode's limit. The sync strobe is delayed by one count, half a line, before it is used. The count value at the moment of restart is the measured divider ratio of the field.

An up/down lock counter steps the divider through four modes. Search takes a wide window. Narrow takes a tight window around the line standard. Qualify keeps the narrow window and counts fields of exactly 525 half-lines. Standard restarts at 525 whether or not a pulse arrives. Fields that match move the counter up. Missing pulses move it down, and that can send the divider back to search. A no-signal flag shortens the search limit so that the divider free-runs at 528. An external force flag, or a pulse seen early in blanking while no signal is present, returns the divider to search.

Top module: `vsync_divider`

## Requirements
- R1: `count_o` rises by exactly 1 every clock and returns to 0 only on a divider restart. `div_reset_o` is high for one clock, the clock in which `count_o` is 0. `ratio_o` then holds the count value reached in the last clock of the ended field and stays unchanged until the next restart.
- R2: Sync is delayed by half a line. A strobe on `vsync_i` in the clock where `count_o` equals c-1 acts in the following clock, so an accepted pulse gives `ratio_o` = c.
- R3: In search (`mode_o` = 0) a pulse is accepted for counts 488 to 576. Pulses outside that range are ignored. With no accepted pulse the divider restarts at 576.
- R4: In narrow (`mode_o` = 1) and qualify (`mode_o` = 2) the window is 522 to 528. With no pulse inside it the divider restarts at 528.
- R5: The lock counter rises by 1 on each accepted pulse and falls by 1 on each field without one. It saturates at 0, at 12 in search and narrow, and at 14 in qualify and standard.
- R6: In search, the accepted pulse that brings the counter to 12 moves the divider to narrow. If that pulse gives ratio 525, the divider moves to qualify instead.
- R7: In narrow, an accepted pulse with the counter at 12 and ratio 525 moves the divider to qualify with the counter cleared. Any other ratio keeps it in narrow.
- R8: In qualify, the 14th counted 525 field moves the divider to standard (`mode_o` = 3). In standard the divider restarts at exactly 525 whether or not a pulse arrives.
- R9: In standard, each field with no pulse at 525 lowers the counter. When the counter reaches 10, the divider returns to search with the counter cleared.
- R10: In narrow, a missed field that drops the counter below 1 returns the divider to search. In qualify, a missed or non-525 field with the counter already at 0 does the same.
- R11: While `no_signal_i` is high in search, the restart limit is 528. Pulses from 488 to 528 are still accepted.
- R12: If `no_signal_i` is high, the last restart was at 528, and a pulse acts at a count of 34 or less, the divider enters search with the counter cleared. A pulse that acts after count 34 does not.
- R13: `force_wide_i` high puts the divider in search with the counter cleared on the next clock.
- R14: Synchronous active-low reset gives `count_o` = 0, `ratio_o` = 0, `mode_o` = 0 and `div_reset_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-line clock (twice the line rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_i | input | 1 | Separated vertical sync strobe |
| no_signal_i | input | 1 | No transmitter identified |
| force_wide_i | input | 1 | External request for search mode |
| count_o | output | 10 | Running half-line count |
| mode_o | output | 2 | 0 search, 1 narrow, 2 qualify, 3 standard |
| div_reset_o | output | 1 | One-clock strobe at divider restart |
| ratio_o | output | 10 | Ratio of the last completed field |

## Verification
The embedded properties assume that every input is synchronous to `clk`. They also assume that `vsync_i` is a strobe, not a level that spans a window. The bench drives inputs on the falling edge. It gives at most one single-clock sync pulse per field and places it by the observed count. It changes the no-signal flag only between fields. It walks the lock counter through every mode transition, and it steps the counter down through each fallback path.

// File: rtl/vdiv_pkg.sv
// Shared types for the vertical divider.
// Assumes nothing beyond a 2-bit mode encoding seen at the top port.
package vdiv_pkg;
    typedef enum logic [1:0] {
        VD_SEARCH   = 2'd0,
        VD_NARROW   = 2'd1,
        VD_QUALIFY  = 2'd2,
        VD_STANDARD = 2'd3
    } vd_mode_e;
endpackage

// File: rtl/vdiv_window.sv
// Window decoder: from the mode and the half-line count, decides whether
// the delayed sync pulse is accepted (hit) and whether the field ends (fire).
// Assumes sync_i is already delayed by half a line and is one clock wide.
module vdiv_window
    import vdiv_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int HL_MIN  = 488,
    parameter int HL_MAX  = 576,
    parameter int NAR_LO  = 522,
    parameter int NAR_HI  = 528,
    parameter int NORM    = 525
) (
    input  vd_mode_e           mode_i,
    input  logic [CNT_W-1:0]   count_i,
    input  logic               sync_i,
    input  logic               no_signal_i,
    output logic               hit_o,
    output logic               fire_o
);
    localparam logic [CNT_W-1:0] K_SMIN = CNT_W'(HL_MIN);
    localparam logic [CNT_W-1:0] K_SMAX = CNT_W'(HL_MAX);
    localparam logic [CNT_W-1:0] K_NLO  = CNT_W'(NAR_LO);
    localparam logic [CNT_W-1:0] K_NHI  = CNT_W'(NAR_HI);
    localparam logic [CNT_W-1:0] K_NORM = CNT_W'(NORM);

    logic [CNT_W-1:0] lo, hi, lim;

    // Select acceptance bounds and restart limit for the current mode.
    always_comb begin
        case (mode_i)
            VD_SEARCH: begin
                lo  = K_SMIN;
                hi  = K_SMAX;
                lim = no_signal_i ? K_NHI : K_SMAX;
            end
            VD_STANDARD: begin
                lo  = K_NORM;
                hi  = K_NORM;
                lim = K_NORM;
            end
            default: begin
                lo  = K_NLO;
                hi  = K_NHI;
                lim = K_NHI;
            end
        endcase
    end

    // Accept a pulse inside the window; end the field on a hit or at the limit.
    assign hit_o  = sync_i && (count_i >= lo) && (count_i <= hi);
    assign fire_o = hit_o || (count_i >= lim);
endmodule

// File: rtl/vdiv_count.sv
// Half-line counter: advances every clock, restarts on fire, latches the
// ratio of the finished field and emits a one-clock restart strobe.
// Assumes fire_i arrives no later than the largest allowed count.
module vdiv_count #(
    parameter int CNT_W  = 10,
    parameter int HL_MAX = 576
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] ratio_o,
    output logic             strobe_o
);
    localparam logic [CNT_W-1:0] K_SMAX = CNT_W'(HL_MAX);

    // Count half-lines, restart and capture the field ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o  <= '0;
            ratio_o  <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= fire_i;
            if (fire_i) begin
                count_o <= '0;
                ratio_o <= count_o;
            end else begin
                count_o <= count_o + 1'b1;
            end
        end
    end

    assert_strobe_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> count_o == '0);
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !strobe_o |-> count_o == $past(count_o) + 1'b1);
    assert_ratio_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !strobe_o |-> $stable(ratio_o));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= K_SMAX);
endmodule

// File: rtl/vdiv_lock.sv
// Lock controller: the mode state machine and the saturating up/down lock
// counter. Acts on field ends (fire/hit) and on the force conditions.
// Assumes count_i is the count of the field that is ending when fire_i is high.
module vdiv_lock
    import vdiv_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int LOCK_W      = 4,
    parameter int NAR_LO      = 522,
    parameter int NAR_HI      = 528,
    parameter int NORM        = 525,
    parameter int BLANK_END   = 34,
    parameter int SEARCH_LOCK = 12,
    parameter int STD_LOCK    = 14,
    parameter int STD_DROP    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             hit_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] last_ratio_i,
    input  logic             no_signal_i,
    input  logic             force_wide_i,
    output vd_mode_e         mode_o
);
    localparam logic [CNT_W-1:0]  K_NLO  = CNT_W'(NAR_LO);
    localparam logic [CNT_W-1:0]  K_NHI  = CNT_W'(NAR_HI);
    localparam logic [CNT_W-1:0]  K_NORM = CNT_W'(NORM);
    localparam logic [CNT_W-1:0]  K_BEND = CNT_W'(BLANK_END);
    localparam logic [LOCK_W-1:0] K_SRCH = LOCK_W'(SEARCH_LOCK);
    localparam logic [LOCK_W-1:0] K_STD  = LOCK_W'(STD_LOCK);
    localparam logic [LOCK_W-1:0] K_DROP = LOCK_W'(STD_DROP);

    vd_mode_e          mode_q, mode_n;
    logic [LOCK_W-1:0] cnt_q, cnt_n, cnt_inc, cnt_dec, sat_n;
    logic              is_norm, reblank;

    assign cnt_inc = cnt_q + 1'b1;
    assign cnt_dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    assign is_norm = (count_i == K_NORM);
    assign reblank = no_signal_i && sync_i && (count_i <= K_BEND) && (last_ratio_i == K_NHI);

    // Next mode and lock count from the field outcome.
    always_comb begin
        mode_n = mode_q;
        cnt_n  = cnt_q;
        sat_n  = (cnt_q >= K_SRCH) ? K_SRCH : cnt_inc;
        if (force_wide_i || reblank) begin
            mode_n = VD_SEARCH;
            cnt_n  = '0;
        end else if (fire_i) begin
            case (mode_q)
                VD_SEARCH: begin
                    if (hit_i) begin
                        if (cnt_inc >= K_SRCH) begin
                            mode_n = is_norm ? VD_QUALIFY : VD_NARROW;
                            cnt_n  = is_norm ? '0 : K_SRCH;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end else begin
                        cnt_n = cnt_dec;
                    end
                end
                VD_NARROW: begin
                    if (hit_i) begin
                        if (sat_n == K_SRCH && is_norm) begin
                            mode_n = VD_QUALIFY;
                            cnt_n  = '0;
                        end else begin
                            cnt_n = sat_n;
                        end
                    end else if (cnt_q <= 1) begin
                        mode_n = VD_SEARCH;
                        cnt_n  = '0;
                    end else begin
                        cnt_n = cnt_dec;
                    end
                end
                VD_QUALIFY: begin
                    if (hit_i && is_norm) begin
                        if (cnt_inc >= K_STD) begin
                            mode_n = VD_STANDARD;
                            cnt_n  = K_STD;
                        end else begin
                            cnt_n = cnt_inc;
                        end
                    end else if (cnt_q == '0) begin
                        mode_n = VD_SEARCH;
                    end else begin
                        cnt_n = cnt_dec;
                    end
                end
                default: begin
                    if (hit_i) begin
                        cnt_n = (cnt_q >= K_STD) ? K_STD : cnt_inc;
                    end else if (cnt_dec <= K_DROP) begin
                        mode_n = VD_SEARCH;
                        cnt_n  = '0;
                    end else begin
                        cnt_n = cnt_dec;
                    end
                end
            endcase
        end
    end

    // Register mode and lock count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= VD_SEARCH;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_n;
            cnt_q  <= cnt_n;
        end
    end

    assign mode_o = mode_q;

    assert_narrow_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == VD_NARROW || mode_q == VD_QUALIFY) && fire_i
        |-> count_i >= K_NLO && count_i <= K_NHI);
    assert_standard_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == VD_STANDARD && fire_i |-> count_i == K_NORM);
    assert_lock_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= K_STD);
    assert_wide_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == VD_SEARCH || mode_q == VD_NARROW) |-> cnt_q <= K_SRCH);
    assert_force_search_R13: assert property (@(posedge clk) disable iff (!rst_n)
        force_wide_i |=> mode_q == VD_SEARCH && cnt_q == '0);
endmodule

// File: rtl/vsync_divider.sv
// Top: windowed synchronized vertical divider. Delays the sync strobe by
// half a line, then joins the window decoder, half-line counter and lock
// controller. Assumes all inputs are synchronous to clk.
module vsync_divider
    import vdiv_pkg::*;
#(
    parameter int HL_MIN      = 488,
    parameter int HL_MAX      = 576,
    parameter int NAR_LO      = 522,
    parameter int NAR_HI      = 528,
    parameter int NORM        = 525,
    parameter int BLANK_END   = 34,
    parameter int SEARCH_LOCK = 12,
    parameter int STD_LOCK    = 14,
    parameter int STD_DROP    = 10,
    localparam int CNT_W      = $clog2(HL_MAX + 1),
    localparam int LOCK_W     = $clog2(STD_LOCK + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic             no_signal_i,
    input  logic             force_wide_i,
    output logic [CNT_W-1:0] count_o,
    output logic [1:0]       mode_o,
    output logic             div_reset_o,
    output logic [CNT_W-1:0] ratio_o
);
    logic     sync_q, hit, fire;
    vd_mode_e mode;

    // Half-line delay of the separated sync strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= vsync_i;
    end

    vdiv_window #(
        .CNT_W(CNT_W), .HL_MIN(HL_MIN), .HL_MAX(HL_MAX),
        .NAR_LO(NAR_LO), .NAR_HI(NAR_HI), .NORM(NORM)
    ) u_window (
        .mode_i(mode), .count_i(count_o), .sync_i(sync_q),
        .no_signal_i(no_signal_i), .hit_o(hit), .fire_o(fire)
    );

    vdiv_count #(.CNT_W(CNT_W), .HL_MAX(HL_MAX)) u_count (
        .clk(clk), .rst_n(rst_n), .fire_i(fire),
        .count_o(count_o), .ratio_o(ratio_o), .strobe_o(div_reset_o)
    );

    vdiv_lock #(
        .CNT_W(CNT_W), .LOCK_W(LOCK_W), .NAR_LO(NAR_LO), .NAR_HI(NAR_HI),
        .NORM(NORM), .BLANK_END(BLANK_END), .SEARCH_LOCK(SEARCH_LOCK),
        .STD_LOCK(STD_LOCK), .STD_DROP(STD_DROP)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .hit_i(hit), .sync_i(sync_q),
        .count_i(count_o), .last_ratio_i(ratio_o), .no_signal_i(no_signal_i),
        .force_wide_i(force_wide_i), .mode_o(mode)
    );

    assign mode_o = mode;
endmodule

// File: tb/tb_vsync_divider.sv
`timescale 1ns/1ps
module tb_vsync_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync_i = 1'b0;
    logic       no_signal_i = 1'b0;
    logic       force_wide_i = 1'b0;
    logic [9:0] count_o, ratio_o;
    logic [1:0] mode_o;
    logic       div_reset_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    vsync_divider dut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .no_signal_i(no_signal_i),
        .force_wide_i(force_wide_i), .count_o(count_o), .mode_o(mode_o),
        .div_reset_o(div_reset_o), .ratio_o(ratio_o)
    );

    // Columns: pulse count (0 = none), fields, no_signal, ratio, mode after, requirement.
    localparam int NV = 20;
    localparam int VEC [NV][6] = '{
        '{500, 11, 0, 500, 0, 2},   // R2 R3: accepted in search
        '{600,  1, 0, 576, 0, 3},   // R3: no pulse, limit 576
        '{400,  1, 0, 576, 0, 3},   // R3: early pulse ignored
        '{524,  3, 0, 524, 1, 6},   // R6: 12th hit, not 525 -> narrow
        '{540,  1, 0, 528, 1, 4},   // R4: outside narrow, restart 528
        '{526,  1, 0, 526, 1, 7},   // R7: hit, not 525, stays narrow
        '{525,  1, 0, 525, 2, 7},   // R7: at 12 with 525 -> qualify
        '{525, 13, 0, 525, 2, 8},   // R8: qualifying
        '{525,  1, 0, 525, 3, 8},   // R8: 14th -> standard
        '{0,    3, 0, 525, 3, 8},   // R8 R9: fixed 525 without pulse
        '{300,  1, 0, 525, 0, 9},   // R9: counter at 10 -> search
        '{0,    1, 1, 528, 0, 11},  // R11: no signal, limit 528
        '{524, 12, 0, 524, 1, 6},   // R6
        '{0,   11, 0, 528, 1, 10},  // R10: counting down in narrow
        '{0,    1, 0, 528, 0, 10},  // R10: below 1 -> search
        '{524, 12, 0, 524, 1, 6},
        '{0,    1, 0, 528, 1, 4},
        '{40,   1, 1, 528, 1, 12},  // R12: pulse after blanking, no effect
        '{20,   1, 1, 528, 0, 12},  // R12: pulse in blanking -> search
        '{500,  1, 1, 500, 0, 11}   // R11: still accepted below 528
    };

    task automatic chk(input int req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Run one field, pulsing sync so it acts at count sync_at; returns the ratio.
    task automatic run_field(input int sync_at, output int got);
        bit sent;
        sent = 0;
        got = -1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            vsync_i = 1'b0;
            if (div_reset_o) begin
                got = ratio_o;
                chk(1, "count at restart strobe", count_o, 0);
                return;
            end
            if (!sent && sync_at >= 1 && int'(count_o) == sync_at - 1) begin
                vsync_i = 1'b1;
                sent = 1;
            end
        end
    endtask

    initial begin
        wait (cycles >= 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        // R14: reset state
        chk(14, "count in reset", count_o, 0);
        chk(14, "mode in reset", mode_o, 0);
        chk(14, "ratio in reset", ratio_o, 0);
        chk(14, "strobe in reset", div_reset_o, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            no_signal_i = VEC[v][2][0];
            for (int k = 0; k < VEC[v][1]; k++) begin
                run_field(VEC[v][0], r);
                chk(VEC[v][5], $sformatf("ratio vec %0d field %0d", v, k), r, VEC[v][3]);
            end
            chk(VEC[v][5], $sformatf("mode after vec %0d", v), mode_o, VEC[v][4]);
        end
        no_signal_i = 1'b0;

        // R1: count steps by one within a field, strobe is one clock
        begin
            int a;
            a = count_o;
            @(negedge clk);
            chk(1, "count step", count_o, a + 1);
            chk(1, "strobe width", div_reset_o, 0);
        end

        // R13: force to search, then the counter must be cleared
        for (int k = 0; k < 11; k++) run_field(524, r);
        chk(6, "mode before force", mode_o, 1);
        force_wide_i = 1'b1;
        @(negedge clk);
        chk(13, "mode after force", mode_o, 0);
        force_wide_i = 1'b0;
        for (int k = 0; k < 11; k++) run_field(524, r);
        chk(13, "mode after 11 hits from cleared counter", mode_o, 0);
        run_field(524, r);
        chk(13, "mode after 12th hit", mode_o, 1);

        // R14: reset in mid-field
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(14, "count after reset", count_o, 0);
        chk(14, "mode after reset", mode_o, 0);
        chk(14, "ratio after reset", ratio_o, 0);
        rst_n = 1'b1;
        run_field(0, r);
        chk(3, "free-run ratio after reset", r, 576);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule